// File: doc/BRIEF.md
# Shift Unit with Condition Codes

This block executes the 32-bit data-register shift operations of a classic CISC integer pipeline and forms the five condition flags that go with them: negative, zero, overflow, carry and extend. It handles left shifts, logical right shifts and arithmetic right shifts. The shift count comes either from a 3-bit field of the instruction word or from a second data register. A register count is taken modulo 64, so counts of 32 to 63 are legal and shift every operand bit out.

A start strobe samples the instruction word, the operand, the count register, the incoming extend flag and two selects. The first select chooses an immediate or a register count. The second chooses between a full overflow rule and a reduced one that always clears overflow. One clock later the shifted value and the new flags appear on registered outputs, and a one-cycle done pulse marks them. The outputs keep their values until the next start.

Top module: `shift_unit`

## Requirements
- R1: In immediate mode the count is instruction bits 11:9. A field value of 0 means a count of 8, so immediate counts run from 1 to 8.
- R2: Instruction bit 8 sets the direction (1 = left, 0 = right). For right shifts, instruction bit 3 picks logical (1) or arithmetic (0).
- R3: In register mode the count is the count register modulo 64. Counts of 32 to 63 give zero for left and logical right shifts, and 32 copies of the sign bit for arithmetic right shifts.
- R4: The carry flag is the last bit shifted out: operand bit (32 − count) for a left shift, and operand bit (count − 1) for a right shift. Bits that lie past the operand read as 0, except for arithmetic right shifts, where they read as the sign bit. The carry flag is 0 when the effective count is 0.
- R5: The negative flag is bit 31 of the result. The zero flag is 1 exactly when all 32 result bits are 0.
- R6: The extend flag takes the carry value when the effective count is non-zero. Otherwise it takes the incoming extend flag unchanged.
- R7: The overflow flag is 0 when the reduced variant is selected (full_v_i = 0), and it is 0 for logical shifts (bit 3 = 1) in either variant.
- R8: With full_v_i = 1 and bit 3 = 0, the overflow flag is the XOR of result bit 31 and operand bit 31, for both directions.
- R9: A left shift gives the same data result whether bit 3 is 0 or 1.
- R10: A register count whose value modulo 64 is 0 returns the operand unchanged as the result.
- R11: Inputs are sampled on the rising clock edge where start_i is 1. Result and flags appear at the next edge together with a one-cycle done_o pulse. Without start_i the outputs hold their values and done_o is 0.
- R12: While rst_ni is low, the result, all flags and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample the inputs and start an operation |
| instr_i | input | 16 | Instruction word (bits 11:9, 8 and 3 are used) |
| operand_i | input | 32 | Value to be shifted |
| count_reg_i | input | 32 | Count register value for register mode |
| x_flag_i | input | 1 | Current extend flag |
| reg_mode_i | input | 1 | 1 = register count, 0 = immediate count |
| full_v_i | input | 1 | 1 = full overflow rule, 0 = overflow always cleared |
| result_o | output | 32 | Shifted value |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| flag_x_o | output | 1 | Extend flag |
| done_o | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The bench builds the block with its default DATA_W of 32, which gives a 6-bit effective count. That width lets register counts of 32, 33, 63, 64 and 95 be driven directly, so the modulo-64 wrap, the full shift-out range and the zero-count extend-hold path can all be exercised. Every immediate field value, including the 0-means-8 case, is run for each direction and right-shift type, and both overflow variants are covered.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  localparam int INSTR_W   = 16;
  localparam int IMM_LSB   = 9;
  localparam int IMM_W     = 3;
  localparam int DIR_BIT   = 8;
  localparam int LOGIC_BIT = 3;
  localparam int IMM_ZERO_CNT = 8;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_LSR  = 2'd1,
    SH_ASR  = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic x;
  } ccr_t;
endpackage

// File: rtl/shu_count_sel.sv
module shu_count_sel
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(2 * DATA_W)
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  count_reg_i,
  input  logic               reg_mode_i,
  output logic [CNT_W-1:0]   cnt_o,
  output shift_kind_e        kind_o,
  output logic               arith_o
);
  logic [IMM_W-1:0] imm_f;
  logic [CNT_W-1:0] imm_cnt;

  assign imm_f   = instr_i[IMM_LSB +: IMM_W];
  assign imm_cnt = (imm_f == '0) ? CNT_W'(IMM_ZERO_CNT) : CNT_W'(imm_f);
  // modulo 2*DATA_W by truncation
  assign cnt_o   = reg_mode_i ? count_reg_i[CNT_W-1:0] : imm_cnt;
  assign arith_o = ~instr_i[LOGIC_BIT];

  always_comb begin
    if (instr_i[DIR_BIT])        kind_o = SH_LEFT;
    else if (instr_i[LOGIC_BIT]) kind_o = SH_LSR;
    else                         kind_o = SH_ASR;
  end
endmodule

// File: rtl/shu_shifter.sv
module shu_shifter
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(2 * DATA_W),
  localparam int EXT_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  logic [EXT_W-1:0] left_ext, right_src, lsr_ext, asr_ext;

  // double-width shift: last bit out sits just beyond the result window
  assign left_ext  = {{DATA_W{1'b0}}, operand_i} << cnt_i;
  assign right_src = {operand_i, {DATA_W{1'b0}}};
  assign lsr_ext   = right_src >> cnt_i;
  assign asr_ext   = $unsigned($signed(right_src) >>> cnt_i);

  always_comb begin
    unique case (kind_i)
      SH_LEFT: begin
        result_o = left_ext[DATA_W-1:0];
        carry_o  = left_ext[DATA_W];
      end
      SH_LSR: begin
        result_o = lsr_ext[EXT_W-1:DATA_W];
        carry_o  = lsr_ext[DATA_W-1];
      end
      default: begin
        result_o = asr_ext[EXT_W-1:DATA_W];
        carry_o  = asr_ext[DATA_W-1];
      end
    endcase
  end
endmodule

// File: rtl/shu_flags.sv
module shu_flags
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(2 * DATA_W)
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              x_flag_i,
  input  logic              arith_i,
  input  logic              full_v_i,
  output ccr_t              ccr_o
);
  logic cnt_nz;
  assign cnt_nz = |cnt_i;

  always_comb begin
    ccr_o.n = result_i[DATA_W-1];
    ccr_o.z = ~|result_i;
    ccr_o.c = cnt_nz & carry_i;
    ccr_o.x = cnt_nz ? carry_i : x_flag_i;
    ccr_o.v = full_v_i & arith_i & (result_i[DATA_W-1] ^ operand_i[DATA_W-1]);
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(2 * DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  operand_i,
  input  logic [DATA_W-1:0]  count_reg_i,
  input  logic               x_flag_i,
  input  logic               reg_mode_i,
  input  logic               full_v_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               flag_n_o,
  output logic               flag_z_o,
  output logic               flag_v_o,
  output logic               flag_c_o,
  output logic               flag_x_o,
  output logic               done_o
);
  logic [CNT_W-1:0]  cnt;
  shift_kind_e       kind;
  logic              arith;
  logic [DATA_W-1:0] sh_res;
  logic              sh_carry;
  ccr_t              ccr_d, ccr_q;
  logic [DATA_W-1:0] res_q;
  logic              done_q;

  shu_count_sel #(.DATA_W(DATA_W)) u_cnt (
    .instr_i     (instr_i),
    .count_reg_i (count_reg_i),
    .reg_mode_i  (reg_mode_i),
    .cnt_o       (cnt),
    .kind_o      (kind),
    .arith_o     (arith)
  );

  shu_shifter #(.DATA_W(DATA_W)) u_shf (
    .operand_i (operand_i),
    .cnt_i     (cnt),
    .kind_i    (kind),
    .result_o  (sh_res),
    .carry_o   (sh_carry)
  );

  shu_flags #(.DATA_W(DATA_W)) u_flg (
    .result_i  (sh_res),
    .operand_i (operand_i),
    .carry_i   (sh_carry),
    .cnt_i     (cnt),
    .x_flag_i  (x_flag_i),
    .arith_i   (arith),
    .full_v_i  (full_v_i),
    .ccr_o     (ccr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      ccr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        res_q <= sh_res;
        ccr_q <= ccr_d;
      end
    end
  end

  assign result_o = res_q;
  assign flag_n_o = ccr_q.n;
  assign flag_z_o = ccr_q.z;
  assign flag_v_o = ccr_q.v;
  assign flag_c_o = ccr_q.c;
  assign flag_x_o = ccr_q.x;
  assign done_o   = done_q;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(2 * DATA_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  operand_i,
  input logic [DATA_W-1:0]  count_reg_i,
  input logic               x_flag_i,
  input logic               reg_mode_i,
  input logic               full_v_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               flag_n_o,
  input logic               flag_z_o,
  input logic               flag_v_o,
  input logic               flag_c_o,
  input logic               flag_x_o,
  input logic               done_o
);
  logic zero_reg_cnt;
  assign zero_reg_cnt = reg_mode_i && (count_reg_i[CNT_W-1:0] == '0);

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R11
  AST_DONE_PULSE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o) && $stable(flag_x_o) && $stable(flag_c_o)); // R11
  AST_NEG_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_n_o == result_o[DATA_W-1]); // R5
  AST_ZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_z_o == (result_o == '0)); // R5
  AST_X_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && zero_reg_cnt) |=> flag_x_o == $past(x_flag_i)); // R6
  AST_X_FOLLOWS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !zero_reg_cnt) |=> flag_x_o == flag_c_o); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (!full_v_i || instr_i[LOGIC_BIT])) |=> !flag_v_o); // R7
  AST_SIGN_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && full_v_i && !instr_i[LOGIC_BIT])
      |=> flag_v_o == (result_o[DATA_W-1] ^ $past(operand_i[DATA_W-1]))); // R8
  AST_ZERO_CNT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && zero_reg_cnt) |=> result_o == $past(operand_i) && !flag_c_o); // R10
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [15:0]   instr_i = '0;
  logic [DW-1:0] operand_i = '0;
  logic [DW-1:0] count_reg_i = '0;
  logic          x_flag_i = 1'b0;
  logic          reg_mode_i = 1'b0;
  logic          full_v_i = 1'b0;
  logic [DW-1:0] result_o;
  logic          flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o, done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  shift_unit #(.DATA_W(DW)) dut_i (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_instr(input int imm, input bit left, input bit logical);
    logic [15:0] w = 16'hE000;
    w[11:9] = 3'(imm);
    w[8] = left;
    w[3] = logical;
    return w;
  endfunction

  // bit-serial reference built from the requirements
  task automatic ref_model(input logic [15:0] ins, input logic [DW-1:0] op,
                           input logic [DW-1:0] creg, input logic xin,
                           input logic regm, input logic full,
                           output logic [DW-1:0] r, output logic n, output logic z,
                           output logic v, output logic c, output logic x);
    int cnt;
    bit left = ins[8];
    bit logical = ins[3];
    if (regm) cnt = int'(creg % 64);
    else cnt = (ins[11:9] == 0) ? 8 : int'(ins[11:9]);
    r = op;
    c = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      if (left) begin
        c = r[DW-1];
        r = {r[DW-2:0], 1'b0};
      end else begin
        c = r[0];
        r = {(logical ? 1'b0 : r[DW-1]), r[DW-1:1]};
      end
    end
    n = r[DW-1];
    z = (r == 0);
    x = (cnt != 0) ? c : xin;
    v = (full && !logical) ? (r[DW-1] ^ op[DW-1]) : 1'b0;
  endtask

  task automatic do_op(input string name, input logic [15:0] ins, input logic [DW-1:0] op,
                       input logic [DW-1:0] creg, input logic xin, input logic regm,
                       input logic full);
    logic [DW-1:0] er;
    logic en, ez, ev, ec, ex;
    ref_model(ins, op, creg, xin, regm, full, er, en, ez, ev, ec, ex);
    @(negedge clk_i);
    instr_i = ins; operand_i = op; count_reg_i = creg;
    x_flag_i = xin; reg_mode_i = regm; full_v_i = full; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk({name, " R11 done"}, DW'(done_o), DW'(1));
    chk({name, " R3 result"}, result_o, er);
    chk({name, " R5 N"}, DW'(flag_n_o), DW'(en));
    chk({name, " R5 Z"}, DW'(flag_z_o), DW'(ez));
    chk({name, " R4 C"}, DW'(flag_c_o), DW'(ec));
    chk({name, " R6 X"}, DW'(flag_x_o), DW'(ex));
    chk({name, " R7/R8 V"}, DW'(flag_v_o), DW'(ev));
  endtask

  task automatic t_reset;
    chk("R12 reset result", result_o, '0);
    chk("R12 reset flags", DW'({flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o, done_o}), '0);
  endtask

  // R1 R2: every immediate field value, each kind
  task automatic t_imm;
    for (int k = 0; k < 8; k++) begin
      do_op("R1 imm left", mk_instr(k, 1, 1), 32'h8123_4561, '0, 1'b0, 1'b0, 1'b0);
      do_op("R2 imm lsr", mk_instr(k, 0, 1), 32'h8123_4561, '0, 1'b0, 1'b0, 1'b1);
      do_op("R2 imm asr", mk_instr(k, 0, 0), 32'h9876_54C3, '0, 1'b1, 1'b0, 1'b1);
    end
    // R1: field 0 means 8, explicit value
    do_op("R1 imm8", mk_instr(0, 0, 1), 32'h0000_0180, '0, 1'b0, 1'b0, 1'b0);
    chk("R1 imm8 result", result_o, 32'h0000_0001);
    chk("R1 imm8 carry", DW'(flag_c_o), DW'(1));
  endtask

  // R3 R4: register counts through the wrap range
  task automatic t_reg_count;
    int cnts[8] = '{1, 31, 32, 33, 40, 63, 64, 95};
    foreach (cnts[i]) begin
      do_op("R3 reg left", mk_instr(1, 1, 1), 32'h8000_0001, 32'(cnts[i]), 1'b1, 1'b1, 1'b1);
      do_op("R3 reg lsr", mk_instr(1, 0, 1), 32'h8000_0001, 32'(cnts[i]), 1'b0, 1'b1, 1'b1);
      do_op("R3 reg asr", mk_instr(1, 0, 0), 32'hC000_0001, 32'(cnts[i]), 1'b0, 1'b1, 1'b1);
    end
    do_op("R3 asr 40", mk_instr(1, 0, 0), 32'h8000_0000, 32'd40, 1'b0, 1'b1, 1'b0);
    chk("R3 asr fill", result_o, 32'hFFFF_FFFF);
    chk("R4 asr carry sign", DW'(flag_c_o), DW'(1));
    do_op("R4 left 32", mk_instr(1, 1, 1), 32'h0000_0001, 32'd32, 1'b0, 1'b1, 1'b0);
    chk("R4 left 32 carry", DW'(flag_c_o), DW'(1));
    chk("R3 left 32 zero", result_o, '0);
  endtask

  // R6 R10: register count reducing to zero
  task automatic t_zero_count;
    do_op("R10 zero cnt x1", mk_instr(1, 1, 1), 32'hDEAD_BEEF, 32'd128, 1'b1, 1'b1, 1'b1);
    chk("R10 passthrough", result_o, 32'hDEAD_BEEF);
    chk("R6 x kept 1", DW'(flag_x_o), DW'(1));
    chk("R4 c cleared", DW'(flag_c_o), DW'(0));
    do_op("R10 zero cnt x0", mk_instr(1, 0, 0), 32'h8000_0001, 32'd0, 1'b0, 1'b1, 1'b1);
    chk("R6 x kept 0", DW'(flag_x_o), DW'(0));
  endtask

  // R7 R8 R9: overflow variants and left-shift type independence
  task automatic t_variant;
    logic [DW-1:0] r_log;
    do_op("R8 asl sign change", mk_instr(1, 1, 0), 32'h4000_0000, '0, 1'b0, 1'b0, 1'b1);
    chk("R8 v set", DW'(flag_v_o), DW'(1));
    r_log = result_o;
    do_op("R7 lsl no v", mk_instr(1, 1, 1), 32'h4000_0000, '0, 1'b0, 1'b0, 1'b1);
    chk("R7 v clear logical", DW'(flag_v_o), DW'(0));
    chk("R9 same data", result_o, r_log);
    do_op("R7 reduced asl", mk_instr(1, 1, 0), 32'h4000_0000, '0, 1'b0, 1'b0, 1'b0);
    chk("R7 v clear reduced", DW'(flag_v_o), DW'(0));
    chk("R9 same data reduced", result_o, r_log);
    do_op("R8 asr no change", mk_instr(3, 0, 0), 32'h8000_0000, '0, 1'b0, 1'b0, 1'b1);
    chk("R8 v clear asr", DW'(flag_v_o), DW'(0));
  endtask

  // R5: zero result
  task automatic t_flags;
    do_op("R5 zero", mk_instr(4, 0, 1), 32'h0000_000F, '0, 1'b0, 1'b0, 1'b0);
    chk("R5 z set", DW'(flag_z_o), DW'(1));
    chk("R5 n clear", DW'(flag_n_o), DW'(0));
  endtask

  // R11: outputs hold without start
  task automatic t_hold;
    logic [DW-1:0] r0;
    logic [5:0] f0;
    do_op("R11 base", mk_instr(2, 1, 1), 32'h1234_5678, '0, 1'b0, 1'b0, 1'b1);
    r0 = result_o;
    f0 = {flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o, 1'b0};
    instr_i = mk_instr(0, 0, 0); operand_i = 32'hFFFF_0000; x_flag_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R11 done low", DW'(done_o), DW'(0));
    chk("R11 result held", result_o, r0);
    chk("R11 flags held", DW'({flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o, 1'b0}), DW'(f0));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R11 watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_imm;
    t_reg_count;
    t_zero_count;
    t_variant;
    t_flags;
    t_hold;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule